// File: doc/BRIEF.md
# Four-Channel Step-Scaled PWM Generator

This block drives four independent pulse-width-modulated outputs from one system clock and a shared base tick. Each channel takes an 8-bit frequency code, an 8-bit duty code, an invert bit and an enable bit. The frequency code holds a 2-bit step size in bits 7:6 and a 6-bit count in bits 5:0. The output frequency is (count+1) times a step. The four steps are 0.5 Hz, 2 Hz, 8 Hz and 32 Hz, each four times the one below. With a suitable base tick rate this spans 0.5 Hz to 2048 Hz.

Each channel keeps a phase accumulator. On every base tick the accumulator grows by (count+1) shifted left by twice the step field. Its top 8 bits give the position within the current period. The channel is active while that position is at or below the duty code, so the active share of a period is (duty+1)/256. Full duty is reachable, but 0 % is not.

The invert bit swaps the active and idle levels. A disabled channel drives low whatever its invert setting. New codes take effect on the next clock without clearing the accumulator, so the period in progress can mix the old and new settings.

Top module: `stepwave_pwm`

## Requirements
- R1: The frequency code field positions are fixed: step = bits 7:6 and count = bits 5:0. On each cycle with `tick_i` high, the channel phase grows by (count+1)·4^step modulo 2^ACC_W.
- R2: On a cycle with `tick_i` low, every channel's phase keeps its value.
- R3: The output register is updated on each clock from the phase and settings present before that edge. An enabled, non-inverted channel is high when the phase's top 8 bits are less than or equal to its duty code, and low otherwise.
- R4: With duty code 255, an enabled, non-inverted channel stays high on every cycle.
- R5: With the invert bit set, an enabled channel is low during the active portion and high otherwise. With duty 255 it stays low.
- R6: A disabled channel drives low one clock later, regardless of its invert bit, duty code or phase.
- R7: Changes to frequency, duty or invert apply from the next clock. The phase is not cleared when they change.
- R8: While `rst_n` is low at a clock edge, all phases clear to zero and all outputs go low on that edge.
- R9: The channels are independent. Channel k (k = 1..4) uses bits [8k-1:8k-8] of both code buses, bit k-1 of `inv_i` and `en_i`, and drives bit k-1 of `pwm_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Base tick; each channel's phase advances on cycles where it is high |
| freq_code_i | input | 8*NUM_CH | Per-channel frequency codes: step in bits 7:6, count in bits 5:0 |
| duty_code_i | input | 8*NUM_CH | Per-channel duty codes; active share is (code+1)/256 |
| inv_i | input | NUM_CH | Per-channel invert bit |
| en_i | input | NUM_CH | Per-channel enable bit |
| pwm_o | output | NUM_CH | Registered PWM outputs |

## Verification
Every result is due exactly one clock after the edge that samples the stimulus. A tick moves the phase at that edge. The output register then shows the phase from before that edge, compared against the settings present at the same edge. The bench drives inputs on falling edges and advances a behavioural model of phase and output on each rising edge. It compares every output on the following falling edge, so each change in frequency, duty, invert, enable or reset is checked on the cycle it first becomes visible. Focused checks add fixed expectations for full duty, inversion, disable and reset.

// File: rtl/stepwave_pkg.sv
package stepwave_pkg;
   localparam int STEP_W = 2;
   localparam int CNT_W  = 6;
   localparam int CODE_W = STEP_W + CNT_W;
   localparam int DUTY_W = 8;
   // largest increment: 64 << 6 needs CNT_W+1+2*(2^STEP_W-1) bits
   localparam int INC_W  = CNT_W + 1 + 2 * ((1 << STEP_W) - 1);

   typedef struct packed {
      logic [STEP_W-1:0] step;
      logic [CNT_W-1:0]  count;
   } freq_code_t;
endpackage

// File: rtl/stepwave_inc.sv
module stepwave_inc
   import stepwave_pkg::*;
(
   input  freq_code_t       code_i,
   output logic [INC_W-1:0] inc_o
);
   logic [CNT_W:0] base;

   always_comb begin
      base  = {1'b0, code_i.count} + {{CNT_W{1'b0}}, 1'b1};
      inc_o = INC_W'(base) << {code_i.step, 1'b0};
   end
endmodule

// File: rtl/stepwave_phase.sv
module stepwave_phase #(
   parameter int ACC_W = 20,
   parameter int INC_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [INC_W-1:0] inc_i,
   output logic [ACC_W-1:0] acc_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      acc_o <= '0;
      else if (tick_i) acc_o <= acc_o + ACC_W'(inc_i);
   end

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> acc_o == ACC_W'($past(acc_o) + ACC_W'($past(inc_i)))); // R1
   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(acc_o)); // R2
   AST_PHASE_CLEAR: assert property (@(posedge clk)
      !rst_n |=> acc_o == '0); // R8
endmodule

// File: rtl/stepwave_chan.sv
module stepwave_chan
   import stepwave_pkg::*;
#(
   parameter int ACC_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  freq_code_t        freq_i,
   input  logic [DUTY_W-1:0] duty_i,
   input  logic              inv_i,
   input  logic              en_i,
   output logic              pwm_o
);
   localparam int POS_LSB = ACC_W - DUTY_W;

   logic [INC_W-1:0]  inc;
   logic [ACC_W-1:0]  acc;
   logic [DUTY_W-1:0] pos;
   logic              active;

   stepwave_inc u_inc (
      .code_i (freq_i),
      .inc_o  (inc)
   );

   stepwave_phase #(.ACC_W(ACC_W), .INC_W(INC_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .inc_i  (inc),
      .acc_o  (acc)
   );

   always_comb begin
      pos    = acc[ACC_W-1:POS_LSB];
      active = (pos <= duty_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pwm_o <= 1'b0;
      else        pwm_o <= en_i & (active ^ inv_i);
   end

   AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !pwm_o); // R6
   AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !inv_i && duty_i == '1) |=> pwm_o); // R4
   AST_FULL_DUTY_INV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && inv_i && duty_i == '1) |=> !pwm_o); // R5
   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |=> !pwm_o); // R8
endmodule

// File: rtl/stepwave_pwm.sv
module stepwave_pwm
   import stepwave_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ACC_W  = 20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick_i,
   input  logic [NUM_CH*CODE_W-1:0] freq_code_i,
   input  logic [NUM_CH*DUTY_W-1:0] duty_code_i,
   input  logic [NUM_CH-1:0]        inv_i,
   input  logic [NUM_CH-1:0]        en_i,
   output logic [NUM_CH-1:0]        pwm_o
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("stepwave_pwm: NUM_CH must be at least 1");
      end
      if (ACC_W <= INC_W || ACC_W < DUTY_W) begin : g_bad_acc
         $error("stepwave_pwm: ACC_W must exceed the increment width");
      end

      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         stepwave_chan #(.ACC_W(ACC_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .freq_i (freq_code_t'(freq_code_i[c*CODE_W +: CODE_W])),
            .duty_i (duty_code_i[c*DUTY_W +: DUTY_W]),
            .inv_i  (inv_i[c]),
            .en_i   (en_i[c]),
            .pwm_o  (pwm_o[c])
         );
      end
   endgenerate
endmodule

// File: tb/stepwave_pwm_test.sv
module stepwave_pwm_test;
   localparam int NCH  = 4;
   localparam int AW   = 20;
   localparam longint MODV = 64'd1 << AW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_i = 1'b0;
   logic [NCH*8-1:0] freq_code_i = '0;
   logic [NCH*8-1:0] duty_code_i = '0;
   logic [NCH-1:0]   inv_i = '0;
   logic [NCH-1:0]   en_i = '0;
   logic [NCH-1:0]   pwm_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur_req = "R8";

   longint     m_acc [NCH];
   logic [NCH-1:0] m_out = '0;

   stepwave_pwm #(.NUM_CH(NCH), .ACC_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .freq_code_i(freq_code_i), .duty_code_i(duty_code_i),
      .inv_i(inv_i), .en_i(en_i), .pwm_o(pwm_o)
   );

   always #5 clk = ~clk;

   initial for (int c = 0; c < NCH; c++) m_acc[c] = 0;

   // behavioural reference: output from pre-edge phase, then phase moves
   always @(posedge clk) begin
      cycles++;
      for (int c = 0; c < NCH; c++) begin
         int step, cnt, duty;
         longint incr;
         step = int'(freq_code_i[c*8+6 +: 2]);
         cnt  = int'(freq_code_i[c*8 +: 6]);
         duty = int'(duty_code_i[c*8 +: 8]);
         if (!rst_n) begin
            m_out[c] = 1'b0;
            m_acc[c] = 0;
         end else begin
            m_out[c] = en_i[c] && (((m_acc[c] >> (AW-8)) <= duty) != inv_i[c]);
            incr = longint'(cnt + 1) * (longint'(1) << (2*step));
            if (tick_i) m_acc[c] = (m_acc[c] + incr) % MODV;
         end
      end
   end

   task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: pwm_o=%b expected %b at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // run n cycles, compare every cycle; tick high once every div cycles
   task automatic run(int n, int div);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(cur_req, pwm_o, m_out);
         tick_i = (div > 0) && (i % div == 0);
      end
   endtask

   function automatic logic [7:0] fc(int step, int cnt);
      return {2'(step), 6'(cnt)};
   endfunction

   initial begin
      // R8: reset state
      cur_req = "R8";
      run(4, 0);
      check("R8", pwm_o, '0);
      @(negedge clk); rst_n = 1'b1;

      // R1 R3 R9: distinct codes per channel, tick every cycle
      cur_req = "R1/R3/R9";
      freq_code_i = {fc(3, 0), fc(2, 63), fc(3, 31), fc(3, 63)};
      duty_code_i = {8'd10, 8'd200, 8'd63, 8'd127};
      en_i = 4'b1111;
      run(3000, 1);

      // R2: sparse ticks, phase must hold between them
      cur_req = "R2";
      freq_code_i = {fc(3, 5), fc(3, 63), fc(2, 40), fc(3, 63)};
      run(1500, 3);
      run(50, 0);

      // R4 R5: full duty and inversion
      cur_req = "R4/R5";
      duty_code_i = {8'd30, 8'd100, 8'd255, 8'd255};
      inv_i = 4'b0110;
      run(600, 1);
      @(negedge clk);
      check("R4", {3'b000, pwm_o[0]}, 4'b0001);
      check("R5", {3'b000, pwm_o[1]}, 4'b0000);

      // R6: disabled channels low even when inverted
      cur_req = "R6";
      inv_i = 4'b1111;
      en_i  = 4'b1010;
      run(700, 1);
      @(negedge clk);
      check("R6", pwm_o & 4'b0101, 4'b0000);

      // R7: settings changed mid-period, phase continues
      cur_req = "R7";
      en_i = 4'b1111;
      for (int k = 0; k < 40; k++) begin
         freq_code_i = {fc(k % 4, 63 - k), fc(3, k), fc(3, 63 - k), fc(3, 20 + k)};
         duty_code_i = {8'(k * 6), 8'(255 - k * 5), 8'(k * 3), 8'(128 + k)};
         inv_i = 4'(k);
         run(37, 1);
      end

      // R8: reset in mid-run
      cur_req = "R8";
      rst_n = 1'b0;
      run(1, 1);
      @(negedge clk);
      check("R8", pwm_o, '0);
      rst_n = 1'b1;
      run(500, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule